// File: doc/BRIEF.md
# Bidirectional IO pin multiplexer

This block routes a set of peripheral function lanes onto a fixed number of IO pad cells. Every pad owns a select register. The value in that register decides which function lane drives the pad's output data. It also decides which lane drives the pad's output enable, so the direction control always travels with the data. The same value decides which lane receives the pad's input data. A general purpose IO function is just another lane with input, output and direction control; nothing in the block treats it specially.

Function lane numbering is computed, not tabulated. Option `s` of pad `p` maps to lane `(p + s) mod NUM_FUNCS`, and each pad offers `NUM_OPTS` options. A select value at or above `NUM_OPTS` parks the pad: its output and output enable are held low. Any lane input that no pad currently selects reads as constant zero. When several pads select the same lane, the lowest-numbered pad feeds that lane's input.

The select registers are reached through a plain address/data port with separate write and read strobes. Reads are combinational. Writes land on the next clock edge. An address that maps to no pad raises an error flag while the access is present.

Top module: `pinmux_top`

## Requirements
- R1: After reset every select register reads 0, so each pad p routes lane p mod NUM_FUNCS (option 0).
- R2: A write with `acc_wr` high and a valid address stores the low SEL_W bits of `acc_wdata` into the select register of pad `acc_addr[ADDR_W-1:2]`, with pads numbered upward from index 0. The new value is visible from the next rising clock edge, and no other register changes.
- R3: While `acc_rd` is high with a valid address, `acc_rdata` shows that pad's select value zero-extended to DATA_W bits in the same cycle. With `acc_rd` low, `acc_rdata` is 0.
- R4: An address is invalid when its index is NUM_PADS or more, or when `acc_addr[1:0]` is not 00. During a write or read to an invalid address, `acc_err` is 1, a write changes no register, and a read returns 0. `acc_err` is 0 for valid accesses and when no strobe is high.
- R5: For pad p with select s < NUM_OPTS, `pad_out[p]` equals `fn_out[(p+s) mod NUM_FUNCS]` and `pad_oe[p]` equals `fn_oe` of that same lane.
- R6: Changing a pad's select value redirects its output data and its output enable together, to the newly chosen lane.
- R7: For a select value s >= NUM_OPTS, `pad_oe[p]` and `pad_out[p]` are both 0 whatever the function lanes drive, and that pad feeds no lane input.
- R8: `fn_in[f]` equals `pad_in` of the lowest-numbered pad whose valid selection maps to lane f. It is 0 if no pad selects lane f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | ADDR_W (8) | Register byte address |
| acc_wdata | input | DATA_W (32) | Write data |
| acc_rdata | output | DATA_W (32) | Read data, combinational |
| acc_err | output | 1 | Invalid-address flag for the current access |
| fn_out | input | NUM_FUNCS (6) | Output data from each function lane |
| fn_oe | input | NUM_FUNCS (6) | Output enable from each function lane |
| fn_in | output | NUM_FUNCS (6) | Input data delivered to each function lane |
| pad_in | input | NUM_PADS (4) | Data arriving from each pad cell |
| pad_out | output | NUM_PADS (4) | Output data to each pad cell |
| pad_oe | output | NUM_PADS (4) | Output enable to each pad cell |

## Verification
Every routing result and every read is combinational, so the bench applies those inputs shortly after a falling edge and samples one time step later, in the same cycle. A write is one cycle: the strobe is held across one rising edge. The routing and readback that depend on the new select value are checked after that edge, once the strobe has dropped at the next falling edge. The error flag is sampled while the strobe is still high. The effect of an invalid write is checked after the edge, by reading every register back and by observing the pads.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // Function lane served by option 'opt' of pad 'pad'.
  function automatic int unsigned lane_of(input int unsigned pad,
                                          input int unsigned opt,
                                          input int unsigned nfn);
    return (pad + opt) % nfn;
  endfunction

  // An option is usable only below the per-pad option count.
  function automatic logic opt_ok(input int unsigned opt,
                                  input int unsigned nopts);
    return opt < nopts;
  endfunction

endpackage

// File: rtl/pinmux_sel_regs.sv
module pinmux_sel_regs #(
  parameter int NUM_PADS = 4,
  parameter int SEL_W    = 2,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_LO   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_wr,
  input  logic                           acc_rd,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [DATA_W-1:0]              acc_wdata,
  output logic [DATA_W-1:0]              acc_rdata,
  output logic                           acc_err,
  output logic [NUM_PADS-1:0][SEL_W-1:0] sel_q
);
  localparam int IDX_W = ADDR_W - IDX_LO;

  logic [IDX_W-1:0]    idx;
  logic [IDX_LO-1:0]   sub;
  logic                addr_ok;
  logic [NUM_PADS-1:0] hit;
  logic [NUM_PADS-1:0] wr_hit;
  logic [SEL_W-1:0]    wsel;

  assign idx     = acc_addr[ADDR_W-1:IDX_LO];
  assign sub     = acc_addr[IDX_LO-1:0];
  assign addr_ok = (sub == '0) && (idx < IDX_W'(NUM_PADS));
  assign acc_err = (acc_wr | acc_rd) & ~addr_ok;
  assign wsel    = acc_wdata[SEL_W-1:0];

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_reg
    assign hit[i]    = addr_ok && (idx == IDX_W'(i));
    assign wr_hit[i] = acc_wr & hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[i] <= '0;
      else if (wr_hit[i]) sel_q[i] <= wsel;
    end

    // R2: written value appears at the next edge, truncated
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> sel_q[i] == $past(acc_wdata[SEL_W-1:0]));
    // R2 / R4: a register keeps its value unless its own write occurs
    assert_hold_unless_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(sel_q[i]));
  end

  always_comb begin
    acc_rdata = '0;
    for (int i = 0; i < NUM_PADS; i++)
      if (acc_rd && hit[i]) acc_rdata = DATA_W'(sel_q[i]);
  end

  // R4: an invalid access never returns data
  assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> acc_rdata == '0);
  // R4: at most one register can be addressed
  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/pinmux_pad_route.sv
module pinmux_pad_route
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int NUM_FUNCS = 6,
  parameter int NUM_OPTS  = 3,
  parameter int SEL_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PADS-1:0][SEL_W-1:0] sel_q,
  input  logic [NUM_FUNCS-1:0]           fn_out,
  input  logic [NUM_FUNCS-1:0]           fn_oe,
  output logic [NUM_PADS-1:0]            pad_out,
  output logic [NUM_PADS-1:0]            pad_oe,
  output logic [NUM_PADS-1:0]            opt_valid
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    always_comb begin
      pad_out[p]   = 1'b0;
      pad_oe[p]    = 1'b0;
      opt_valid[p] = 1'b0;
      for (int o = 0; o < (1 << SEL_W); o++) begin
        if (sel_q[p] == SEL_W'(o) && opt_ok(o, NUM_OPTS)) begin
          opt_valid[p] = 1'b1;
          pad_out[p]   = fn_out[lane_of(p, o, NUM_FUNCS)];
          pad_oe[p]    = fn_oe[lane_of(p, o, NUM_FUNCS)];
        end
      end
    end

    // R7: a parked pad drives nothing
    assert_parked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_valid[p] |-> (!pad_oe[p] && !pad_out[p]));
  end
endmodule

// File: rtl/pinmux_in_route.sv
module pinmux_in_route
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int NUM_FUNCS = 6,
  parameter int SEL_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PADS-1:0][SEL_W-1:0] sel_q,
  input  logic [NUM_PADS-1:0]            opt_valid,
  input  logic [NUM_PADS-1:0]            pad_in,
  output logic [NUM_FUNCS-1:0]           fn_in,
  output logic [NUM_FUNCS-1:0]           fn_claimed
);
  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_lane
    always_comb begin
      fn_in[f]      = 1'b0;
      fn_claimed[f] = 1'b0;
      // scan downward so the lowest pad is written last and wins
      for (int p = NUM_PADS - 1; p >= 0; p--) begin
        if (opt_valid[p] &&
            lane_of(p, int'(sel_q[p]), NUM_FUNCS) == f) begin
          fn_in[f]      = pad_in[p];
          fn_claimed[f] = 1'b1;
        end
      end
    end

    // R8: an unselected lane reads zero
    assert_unclaimed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fn_claimed[f] |-> !fn_in[f]);
  end
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top #(
  parameter int NUM_PADS  = 4,
  parameter int NUM_FUNCS = 6,
  parameter int NUM_OPTS  = 3,
  parameter int SEL_W     = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [DATA_W-1:0]    acc_wdata,
  output logic [DATA_W-1:0]    acc_rdata,
  output logic                 acc_err,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe,
  output logic [NUM_FUNCS-1:0] fn_in,
  input  logic [NUM_PADS-1:0]  pad_in,
  output logic [NUM_PADS-1:0]  pad_out,
  output logic [NUM_PADS-1:0]  pad_oe
);
  localparam int IDX_LO = 2;

  logic [NUM_PADS-1:0][SEL_W-1:0] sel_q;
  logic [NUM_PADS-1:0]            opt_valid;
  logic [NUM_FUNCS-1:0]           fn_claimed;

  pinmux_sel_regs #(
    .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_LO(IDX_LO)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .sel_q(sel_q)
  );

  pinmux_pad_route #(
    .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS), .NUM_OPTS(NUM_OPTS),
    .SEL_W(SEL_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .fn_out(fn_out),
    .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .opt_valid(opt_valid)
  );

  pinmux_in_route #(
    .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS), .SEL_W(SEL_W)
  ) u_in (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .opt_valid(opt_valid),
    .pad_in(pad_in), .fn_in(fn_in), .fn_claimed(fn_claimed)
  );

  // R6: with selects and lanes steady, a valid pad's enable is steady too
  assert_oe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(sel_q) && $stable(fn_oe)) |-> $stable(pad_oe));
endmodule

// File: tb/pinmux_top_test.sv
`timescale 1ns/1ps
module pinmux_top_test;
  localparam int NP = 4, NF = 6, NO = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        acc_wr = 0, acc_rd = 0;
  logic [7:0]  acc_addr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic        acc_err;
  logic [NF-1:0] fn_out = 0, fn_oe = 0, fn_in;
  logic [NP-1:0] pad_in = 0, pad_out, pad_oe;

  int total = 0, bad = 0;
  int shadow [NP];

  always #2.5 clk = ~clk;

  pinmux_top uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lane(input int p, input int s);
    int t = p + s;
    while (t >= NF) t -= NF;
    return t;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                          input logic exp_err, input string req);
    @(negedge clk);
    acc_wr = 1; acc_addr = a; acc_wdata = d;
    #1 chk({req, " write err"}, acc_err, exp_err);
    @(negedge clk);
    acc_wr = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp_d,
                         input logic exp_err, input string req);
    @(negedge clk);
    acc_rd = 1; acc_addr = a;
    #1 chk({req, " read data"}, acc_rdata, exp_d);
    chk({req, " read err"}, acc_err, exp_err);
    acc_rd = 0;
  endtask

  task automatic check_routes(input string req);
    logic [NP-1:0] eo, ee;
    logic [NF-1:0] ei;
    eo = '0; ee = '0; ei = '0;
    for (int p = 0; p < NP; p++)
      if (shadow[p] < NO) begin
        eo[p] = fn_out[lane(p, shadow[p])];
        ee[p] = fn_oe[lane(p, shadow[p])];
      end
    for (int f = 0; f < NF; f++) begin
      bit found = 0;
      for (int p = 0; p < NP; p++)
        if (!found && shadow[p] < NO && lane(p, shadow[p]) == f) begin
          ei[f] = pad_in[p]; found = 1;
        end
    end
    #1;
    chk({req, " pad_out"}, 32'(pad_out), 32'(eo));
    chk({req, " pad_oe"}, 32'(pad_oe), 32'(ee));
    chk({req, " fn_in"}, 32'(fn_in), 32'(ei));
  endtask

  task automatic t_reset;
    for (int p = 0; p < NP; p++) do_read(8'(p * 4), 0, 0, "R1");
    @(negedge clk);
    fn_out = 6'b101101; fn_oe = 6'b011011; pad_in = 4'b1011;
    check_routes("R1");
    chk("R4 idle err", acc_err, 0);
  endtask

  task automatic t_write_read;
    int vals [NP] = '{1, 2, 0, 1};
    for (int p = 0; p < NP; p++) begin
      do_write(8'(p * 4), 32'(vals[p]), 0, "R2");
      shadow[p] = vals[p];
    end
    for (int p = 0; p < NP; p++) do_read(8'(p * 4), 32'(vals[p]), 0, "R3");
    do_write(8'h04, 32'hFFFF_FFF6, 0, "R2 trunc");
    shadow[1] = 2;
    do_read(8'h04, 32'd2, 0, "R2 trunc");
    do_read(8'h00, 32'd1, 0, "R2 others kept");
    @(negedge clk); acc_addr = 8'h04;
    #1 chk("R3 no strobe", acc_rdata, 0);
  endtask

  task automatic t_unmapped;
    do_write(8'h14, 32'd2, 1, "R4 idx5");
    do_write(8'h01, 32'd2, 1, "R4 misaligned");
    do_write(8'hFC, 32'd2, 1, "R4 top");
    for (int p = 0; p < NP; p++) do_read(8'(p * 4), 32'(shadow[p]), 0, "R4 unchanged");
    do_read(8'h24, 0, 1, "R4 read idx9");
    do_read(8'h06, 0, 1, "R4 read misaligned");
    @(negedge clk); check_routes("R4 pads unchanged");
  endtask

  task automatic t_route;
    logic [NF-1:0] pats [3] = '{6'b110010, 6'b001101, 6'b111111};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fn_out = pats[k]; fn_oe = ~pats[k]; pad_in = 4'(k + 5);
      check_routes("R5");
    end
    // R6: pad 0 from lane 0 to lane 1 with opposite enables and data
    @(negedge clk);
    fn_out = 6'b000001; fn_oe = 6'b000001;
    do_write(8'h00, 0, 0, "R6"); shadow[0] = 0;
    #1 chk("R6 before oe", pad_oe[0], 1); chk("R6 before out", pad_out[0], 1);
    do_write(8'h00, 1, 0, "R6"); shadow[0] = 1;
    #1 chk("R6 after oe", pad_oe[0], 0); chk("R6 after out", pad_out[0], 0);
    check_routes("R6");
  endtask

  task automatic t_invalid;
    do_write(8'h08, 3, 0, "R7"); shadow[2] = 3;
    @(negedge clk);
    fn_out = '1; fn_oe = '1; pad_in = 4'b0100;
    #1 chk("R7 oe", pad_oe[2], 0); chk("R7 out", pad_out[2], 0);
    check_routes("R7");
  endtask

  task automatic t_priority;
    // pads 0 and 1 both on lane 1; pads 2,3 parked
    do_write(8'h00, 1, 0, "R8"); shadow[0] = 1;
    do_write(8'h04, 0, 0, "R8"); shadow[1] = 0;
    do_write(8'h0C, 3, 0, "R8"); shadow[3] = 3;
    @(negedge clk); pad_in = 4'b0010;
    #1 chk("R8 lowest wins 0", fn_in[1], 0);
    chk("R8 unclaimed", 32'(fn_in & 6'b111101), 0);
    @(negedge clk); pad_in = 4'b0001;
    #1 chk("R8 lowest wins 1", fn_in[1], 1);
    check_routes("R8");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) shadow[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_read();
    t_unmapped();
    t_route();
    t_invalid();
    t_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule